// File: doc/BRIEF.md
# Register File with Run-Time Selectable Program Counter and Index Pointer

This block holds sixteen 16-bit general registers and two 4-bit selectors. The program selector picks the register that acts as the program counter. The index selector picks the register that acts as the memory pointer. Any register can take either role, and the role can change while the program runs. A subroutine call or return therefore needs only a write to the program selector. No registers have to be copied.

The block executes one register operation per clock. The operation code and a 4-bit register number arrive on its inputs. The operations are:

- byte transfers between a register half and an 8-bit accumulator byte;
- increment and decrement of a whole register;
- selector loads;
- opcode fetch, output access and input access, which use the program or index register;
- a plain operation that puts a named register on the address output.

The address output is combinational and always carries the value from before any update in that cycle. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `regsel_file`

## Requirements
- R1: While reset is held, and after it is released, all sixteen registers read 0, both selectors read 0, and `addr_out` shows register 0 (0x0000).
- R2: Op code 8 (set program selector) loads `sel` into `p_sel` at the clock edge. Every later fetch uses the newly chosen register.
- R3: Op code 9 (set index selector) loads `sel` into `x_sel` at the clock edge. Later output and input accesses use that register.
- R4: Op code 1 (fetch) drives the program register on `addr_out` in that cycle. At the clock edge the program register increases by 1.
- R5: Op code 2 (get low) drives bits [7:0] of register `sel` on `byte_out` in the same cycle. Op code 3 (get high) drives bits [15:8] of register `sel` on `byte_out`.
- R6: Op code 4 (put low) writes `acc_in` into bits [7:0] of register `sel`. Op code 5 (put high) writes `acc_in` into bits [15:8] of register `sel`. The other byte of the register keeps its value.
- R7: Op code 10 (output access) drives the index register on `addr_out`. At the clock edge the index register increases by 1.
- R8: Op code 11 (input access) drives the index register on `addr_out` and leaves that register unchanged.
- R9: Op code 6 adds 1 to register `sel` and op code 7 subtracts 1 from it. Both wrap modulo 65536 (0xFFFF+1 gives 0x0000, and 0x0000-1 gives 0xFFFF).
- R10: `addr_out` always carries the value from before any update in the cycle, even when the same register is also incremented. Op code 12 drives register `sel` on it. Op codes 0, 2 to 9 and 13 to 15 drive the program register on it.
- R11: Op code 0 and the unused codes 13 to 15 change no register and neither selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code for this cycle |
| sel | input | 4 | Register number used by the operation |
| acc_in | input | 8 | Accumulator byte for put operations |
| addr_out | output | 16 | Address taken from the selected register, pre-update |
| byte_out | output | 8 | Selected byte of register `sel` |
| p_sel | output | 4 | Current program-counter selector |
| x_sel | output | 4 | Current index selector |

## Verification
The assertions assume that `op` and `sel` are stable and known from the first cycle after the synchronized reset is released. The bench holds `op` at 0 during reset, so no operation is seen at release. It changes inputs only at falling edges, so each code is present for exactly one full cycle. The properties also assume that the op code, not the register number, decides whether state changes. The stimulus therefore includes cycles where the program and index selectors name the same register, and cycles with unused codes that carry live register numbers.

// File: rtl/regsel_pkg.sv
package regsel_pkg;
  localparam int REG_W  = 16;
  localparam int NREG   = 16;
  localparam int SEL_W  = $clog2(NREG);
  localparam int BYTE_W = REG_W / 2;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_FETCH  = 4'd1,
    OP_GET_LO = 4'd2,
    OP_GET_HI = 4'd3,
    OP_PUT_LO = 4'd4,
    OP_PUT_HI = 4'd5,
    OP_INC    = 4'd6,
    OP_DEC    = 4'd7,
    OP_SET_P  = 4'd8,
    OP_SET_X  = 4'd9,
    OP_OUT    = 4'd10,
    OP_IN     = 4'd11,
    OP_ADDR   = 4'd12
  } op_e;
endpackage

// File: rtl/regsel_rst_sync.sv
module regsel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      s1_q   <= 1'b1;
      rst_ns <= s1_q;
    end
  end
endmodule

// File: rtl/regsel_cell.sv
module regsel_cell #(
  parameter int W = 16,
  localparam int H = W / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [H-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] d;
  logic         en;

  always_comb begin
    d = q;
    if (inc) begin
      d = q + W'(1);
    end else if (dec) begin
      d = q - W'(1);
    end else begin
      if (wr_lo) d[H-1:0] = din;
      if (wr_hi) d[W-1:H] = din;
    end
  end

  assign en = inc | dec | wr_lo | wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/regsel_decode.sv
module regsel_decode
  import regsel_pkg::*;
#(
  parameter int N  = NREG,
  parameter int SW = SEL_W
) (
  input  logic [3:0]    op,
  input  logic [SW-1:0] sel,
  input  logic [SW-1:0] p_cur,
  input  logic [SW-1:0] x_cur,
  output logic [N-1:0]  inc_v,
  output logic [N-1:0]  dec_v,
  output logic [N-1:0]  wrlo_v,
  output logic [N-1:0]  wrhi_v,
  output logic          p_ld,
  output logic          x_ld,
  output logic [SW-1:0] addr_idx,
  output logic          hi_byte
);
  localparam logic [N-1:0] ONE = N'(1);

  always_comb begin
    inc_v    = '0;
    dec_v    = '0;
    wrlo_v   = '0;
    wrhi_v   = '0;
    p_ld     = 1'b0;
    x_ld     = 1'b0;
    addr_idx = p_cur;
    hi_byte  = 1'b0;
    case (op)
      4'(OP_FETCH):  inc_v  = ONE << p_cur;
      4'(OP_GET_HI): hi_byte = 1'b1;
      4'(OP_PUT_LO): wrlo_v = ONE << sel;
      4'(OP_PUT_HI): wrhi_v = ONE << sel;
      4'(OP_INC):    inc_v  = ONE << sel;
      4'(OP_DEC):    dec_v  = ONE << sel;
      4'(OP_SET_P):  p_ld   = 1'b1;
      4'(OP_SET_X):  x_ld   = 1'b1;
      4'(OP_OUT): begin
        inc_v    = ONE << x_cur;
        addr_idx = x_cur;
      end
      4'(OP_IN):     addr_idx = x_cur;
      4'(OP_ADDR):   addr_idx = sel;
      default: ;
    endcase
  end
endmodule

// File: rtl/regsel_read.sv
module regsel_read
  import regsel_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int N  = NREG,
  parameter int SW = SEL_W,
  localparam int H = W / 2
) (
  input  logic [W-1:0]  regs [N],
  input  logic [SW-1:0] addr_idx,
  input  logic [SW-1:0] sel,
  input  logic          hi_byte,
  output logic [W-1:0]  addr_out,
  output logic [H-1:0]  byte_out
);
  logic [W-1:0] rsel;

  always_comb begin
    addr_out = regs[addr_idx];
    rsel     = regs[sel];
    byte_out = hi_byte ? rsel[W-1:H] : rsel[H-1:0];
  end
endmodule

// File: rtl/regsel_file.sv
module regsel_file
  import regsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] acc_in,
  output logic [REG_W-1:0]  addr_out,
  output logic [BYTE_W-1:0] byte_out,
  output logic [SEL_W-1:0]  p_sel,
  output logic [SEL_W-1:0]  x_sel
);
  logic             rst_ns;
  logic [REG_W-1:0] regs [NREG];
  logic [NREG-1:0]  inc_v, dec_v, wrlo_v, wrhi_v;
  logic             p_ld, x_ld, hi_byte;
  logic [SEL_W-1:0] addr_idx;
  logic [SEL_W-1:0] p_d, x_d;

  regsel_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  regsel_decode #(.N(NREG), .SW(SEL_W)) u_dec (
    .op       (op),
    .sel      (sel),
    .p_cur    (p_sel),
    .x_cur    (x_sel),
    .inc_v    (inc_v),
    .dec_v    (dec_v),
    .wrlo_v   (wrlo_v),
    .wrhi_v   (wrhi_v),
    .p_ld     (p_ld),
    .x_ld     (x_ld),
    .addr_idx (addr_idx),
    .hi_byte  (hi_byte)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    regsel_cell #(.W(REG_W)) u_cell (
      .clk   (clk),
      .rst_n (rst_ns),
      .inc   (inc_v[g]),
      .dec   (dec_v[g]),
      .wr_lo (wrlo_v[g]),
      .wr_hi (wrhi_v[g]),
      .din   (acc_in),
      .q     (regs[g])
    );
  end

  regsel_read #(.W(REG_W), .N(NREG), .SW(SEL_W)) u_rd (
    .regs     (regs),
    .addr_idx (addr_idx),
    .sel      (sel),
    .hi_byte  (hi_byte),
    .addr_out (addr_out),
    .byte_out (byte_out)
  );

  always_comb begin
    p_d = p_ld ? sel : p_sel;
    x_d = x_ld ? sel : x_sel;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      p_sel <= '0;
      x_sel <= '0;
    end else begin
      if (p_ld) p_sel <= p_d;
      if (x_ld) x_sel <= x_d;
    end
  end
endmodule

// File: rtl/regsel_chk.sv
module regsel_chk
  import regsel_pkg::*;
(
  input logic              clk,
  input logic              rst_ns,
  input logic [3:0]        op,
  input logic [SEL_W-1:0]  sel,
  input logic [REG_W-1:0]  addr_out,
  input logic [SEL_W-1:0]  p_sel,
  input logic [SEL_W-1:0]  x_sel,
  input logic [REG_W-1:0]  regs [NREG]
);
  localparam int H = REG_W / 2;

  p_fetch_inc_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (op == 4'(OP_FETCH)) |=> regs[$past(p_sel)] == $past(addr_out) + REG_W'(1));

  p_set_p_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (op == 4'(OP_SET_P)) |=> p_sel == $past(sel));

  p_set_x_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (op == 4'(OP_SET_X)) |=> x_sel == $past(sel));

  p_out_inc_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (op == 4'(OP_OUT)) |=> regs[$past(x_sel)] == $past(addr_out) + REG_W'(1));

  p_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (op == 4'(OP_IN)) |=> regs[$past(x_sel)] == $past(addr_out));

  p_dec_wrap_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (op == 4'(OP_DEC)) |=> regs[$past(sel)] == $past(regs[sel]) - REG_W'(1));

  p_put_keep_hi_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (op == 4'(OP_PUT_LO)) |=> regs[$past(sel)][REG_W-1:H] == $past(regs[sel][REG_W-1:H]));

  p_idle_sel_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    (op == 4'(OP_NOP)) |=> $stable(p_sel) && $stable(x_sel));
endmodule

bind regsel_file regsel_chk u_chk (
  .clk      (clk),
  .rst_ns   (rst_ns),
  .op       (op),
  .sel      (sel),
  .addr_out (addr_out),
  .p_sel    (p_sel),
  .x_sel    (x_sel),
  .regs     (regs)
);

// File: tb/sim_regsel_file.sv
module sim_regsel_file;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op, sel;
  logic [7:0]  acc_in;
  logic [15:0] addr_out;
  logic [7:0]  byte_out;
  logic [3:0]  p_sel, x_sel;

  regsel_file u0 (
    .clk(clk), .rst_n(rst_n), .op(op), .sel(sel), .acc_in(acc_in),
    .addr_out(addr_out), .byte_out(byte_out), .p_sel(p_sel), .x_sel(x_sel)
  );

  always #(PER/2) clk = ~clk;

  typedef struct {
    string       tag;
    logic [15:0] a;
    logic [7:0]  b;
    logic [3:0]  p, x;
    bit          cb;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_bad = 0;
  bit          done  = 0;
  logic [15:0] m_r [16];
  logic [3:0]  m_p, m_x;

  task automatic do_op(input logic [3:0] o, input logic [3:0] s,
                       input logic [7:0] acc, input string tag);
    exp_t e;
    logic [3:0] ai;
    @(negedge clk);
    op = o; sel = s; acc_in = acc;
    ai = (o == 4'd10 || o == 4'd11) ? m_x : (o == 4'd12) ? s : m_p;
    e.tag = tag;
    e.a   = m_r[ai];
    e.b   = (o == 4'd3) ? m_r[s][15:8] : m_r[s][7:0];
    e.cb  = (o == 4'd2 || o == 4'd3);
    e.p   = m_p;
    e.x   = m_x;
    sb.push_back(e);
    case (o)
      4'd1:  m_r[m_p] = m_r[m_p] + 16'd1;
      4'd4:  m_r[s][7:0]  = acc;
      4'd5:  m_r[s][15:8] = acc;
      4'd6:  m_r[s] = m_r[s] + 16'd1;
      4'd7:  m_r[s] = m_r[s] - 16'd1;
      4'd8:  m_p = s;
      4'd9:  m_x = s;
      4'd10: m_r[m_x] = m_r[m_x] + 16'd1;
      default: ;
    endcase
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        n_chk++;
        if (addr_out !== e.a) begin
          n_bad++;
          $display("FAIL %s addr_out act=%h exp=%h", e.tag, addr_out, e.a);
        end
        n_chk++;
        if (p_sel !== e.p || x_sel !== e.x) begin
          n_bad++;
          $display("FAIL %s p/x act=%h/%h exp=%h/%h", e.tag, p_sel, x_sel, e.p, e.x);
        end
        if (e.cb) begin
          n_chk++;
          if (byte_out !== e.b) begin
            n_bad++;
            $display("FAIL %s byte_out act=%h exp=%h", e.tag, byte_out, e.b);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(PER * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 16; i++) m_r[i] = 16'h0000;
    m_p = 4'd0; m_x = 4'd0;
    rst_n = 1'b0; op = 4'd0; sel = 4'd0; acc_in = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state of every register and both selectors
    for (int i = 0; i < 16; i++) do_op(4'd12, 4'(i), 8'h00, "R1");
    do_op(4'd0, 4'd7, 8'h00, "R1");

    // R6 / R5: fill both halves, then read them back
    for (int i = 0; i < 16; i++) begin
      do_op(4'd4, 4'(i), 8'(8'h5A ^ i), "R6");
      do_op(4'd5, 4'(i), 8'(i * 17), "R6");
    end
    for (int i = 0; i < 16; i += 3) begin
      do_op(4'd2, 4'(i), 8'h00, "R5");
      do_op(4'd3, 4'(i), 8'h00, "R5");
      do_op(4'd12, 4'(i), 8'h00, "R10");
    end
    do_op(4'd4, 4'd6, 8'hC3, "R6");
    do_op(4'd3, 4'd6, 8'h00, "R6");
    do_op(4'd2, 4'd6, 8'h00, "R6");

    // R4 / R10: fetch from register 0, address shows the pre-increment value
    for (int i = 0; i < 3; i++) do_op(4'd1, 4'd0, 8'h00, "R4");
    // R2: move the program counter to register 5
    do_op(4'd8, 4'd5, 8'h00, "R2");
    for (int i = 0; i < 3; i++) do_op(4'd1, 4'd0, 8'h00, "R2");
    do_op(4'd12, 4'd0, 8'h00, "R2");

    // R3 / R7 / R8: index register 9, output increments, input holds
    do_op(4'd9, 4'd9, 8'h00, "R3");
    do_op(4'd10, 4'd0, 8'h00, "R7");
    do_op(4'd10, 4'd0, 8'h00, "R7");
    do_op(4'd11, 4'd0, 8'h00, "R8");
    do_op(4'd11, 4'd0, 8'h00, "R8");
    do_op(4'd12, 4'd9, 8'h00, "R8");

    // R9: wrap in both directions
    do_op(4'd4, 4'd3, 8'hFF, "R9");
    do_op(4'd5, 4'd3, 8'hFF, "R9");
    do_op(4'd6, 4'd3, 8'h00, "R9");
    do_op(4'd12, 4'd3, 8'h00, "R9");
    do_op(4'd7, 4'd3, 8'h00, "R9");
    do_op(4'd12, 4'd3, 8'h00, "R9");
    do_op(4'd7, 4'd3, 8'h00, "R9");
    do_op(4'd12, 4'd3, 8'h00, "R9");

    // R10: index equals program register, output access on the shared one
    do_op(4'd9, 4'd5, 8'h00, "R10");
    do_op(4'd10, 4'd0, 8'h00, "R10");
    do_op(4'd1, 4'd0, 8'h00, "R10");
    do_op(4'd0, 4'd0, 8'h00, "R10");

    // R11: idle and unused codes with live register numbers
    do_op(4'd13, 4'd5, 8'h11, "R11");
    do_op(4'd14, 4'd9, 8'h22, "R11");
    do_op(4'd15, 4'd3, 8'h33, "R11");
    do_op(4'd0, 4'd1, 8'h44, "R11");
    for (int i = 0; i < 16; i++) do_op(4'd12, 4'(i), 8'h00, "R11");

    do_op(4'd0, 4'd0, 8'h00, "R11");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule